// File: doc/BRIEF.md
# Programmable Interval Timer With Modulo Reload

This block is an 8-bit interval timer clocked from a free-running 16-bit cycle divider. A two-bit rate code picks one of four divider bits as the tick source. Each time the picked bit, gated by the enable flag, falls from 1 to 0, the timer counter advances by one. When the counter passes 0xFF it does not wrap to zero. It takes its next value from a separate reload register and raises a one-cycle interrupt request toward an external interrupt controller.

Software reaches the block through a small register port. Writes are single-cycle strobes, and read data is combinational from the addressed register. Four registers are visible. The upper byte of the divider is at address 0, and any write there clears the whole divider. The counter is at address 1, the reload value at address 2, and the control register at address 3. The gating is literal: a falling edge seen on the tick source counts, even when a divider clear or a disable caused it.

Top module: `modulo_interval_timer`

## Requirements
- R1: After reset every register reads 0x00 and `timerIrq` is low.
- R2: Address 1 (counter) and address 2 (reload value) are 8-bit read/write registers. Address 3 holds the enable in bit 2 and the rate code in bits 1:0. Bits 7:3 of address 3 read as zero.
- R3: The divider is a 16-bit count that advances by one on every clock. Address 0 reads divider bits 15:8, and any write to address 0 clears all 16 bits.
- R4: Rate code 01 ticks the counter every 4 cycles, 10 every 16, 11 every 64 and 00 every 256. These periods come from falling edges of divider bits 1, 3, 5 and 7. The counter changes on the clock edge after the edge on which the selected bit dropped.
- R5: Enable is bit 2 of address 3. While it is 0 the counter holds its value.
- R6: A tick that finds the counter at 0xFF loads the reload register's value into the counter instead of 0x00.
- R7: Each overflow drives `timerIrq` high for exactly one clock cycle.
- R8: If clearing the divider or clearing the enable makes the gated tick source fall from 1 to 0, that fall counts as one extra tick.
- R9: A write to the counter on the same edge as a tick stores the written value, and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one divider step per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select: 0 divider, 1 counter, 2 reload, 3 control |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| timerIrq | output | 1 | One-cycle overflow interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 16-bit divider, and tick bits 7, 1, 3 and 5 for rate codes 00 to 11. The slowest period is 256 cycles, so every rate code, including overflows and repeated reloads, fits in a few hundred cycles per case. A 16-bit divider also lets the readout of the upper byte be checked after a few hundred cycles. Directed cases place divider clears, disables and counter writes on chosen edges relative to a tick, to reach the extra-tick and write-priority corners.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // register addresses; the read mux and the write decode both use them
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_DIV = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] REG_MOD = 2'd2;
  localparam logic [ADDR_W-1:0] REG_CTL = 2'd3;

  // control register layout
  localparam int unsigned CTL_EN_BIT = 2;
  localparam int unsigned CTL_W      = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic cntWr;
    logic modWr;
    logic tick;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned TAP_R0 = 7,
  parameter int unsigned TAP_R1 = 1,
  parameter int unsigned TAP_R2 = 3,
  parameter int unsigned TAP_R3 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CTL_W-1:0]  ctlWdata,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] divHigh,
  output logic [CTL_W-1:0]  ctlReg
);
  localparam int unsigned TAP_IDX_W = $clog2(DIV_W);
  localparam int unsigned DIV_HI_LSB = DIV_W - DATA_W;

  logic [DIV_W-1:0]     divCnt;
  logic [TAP_IDX_W-1:0] tapIdx;
  logic                 timerEn;
  logic [1:0]           rateSel;
  logic                 tapNow;
  logic                 tapPrev;
  logic                 wrDiv;
  logic                 wrCtl;

  assign wrDiv = busWe && (busAddr == REG_DIV);
  assign wrCtl = busWe && (busAddr == REG_CTL);

  // free-running divider, cleared by any write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divCnt <= '0;
    else if (wrDiv) divCnt <= '0;
    else            divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerEn <= 1'b0;
      rateSel <= 2'b00;
    end else if (wrCtl) begin
      timerEn <= ctlWdata[CTL_EN_BIT];
      rateSel <= ctlWdata[1:0];
    end
  end

  // non-monotonic rate code to divider bit
  always_comb begin
    unique case (rateSel)
      2'b00:   tapIdx = TAP_IDX_W'(TAP_R0);
      2'b01:   tapIdx = TAP_IDX_W'(TAP_R1);
      2'b10:   tapIdx = TAP_IDX_W'(TAP_R2);
      default: tapIdx = TAP_IDX_W'(TAP_R3);
    endcase
  end

  assign tapNow = divCnt[tapIdx] & timerEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapPrev <= 1'b0;
    else       tapPrev <= tapNow;
  end

  assign strobe.tick  = tapPrev & ~tapNow;
  assign strobe.cntWr = busWe && (busAddr == REG_CNT);
  assign strobe.modWr = busWe && (busAddr == REG_MOD);

  assign divHigh = divCnt[DIV_W-1:DIV_HI_LSB];
  assign ctlReg  = {timerEn, rateSel};

  // R3: divider steps by one each cycle unless written
  a_r3_div_runs: assert property (@(posedge clk) disable iff (!rstN)
    !wrDiv |=> divCnt == $past(divCnt) + 1'b1);

  // R3: a write clears the divider
  a_r3_div_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrDiv |=> divCnt == '0);

  // R5: no tick may follow a cycle with the enable off
  a_r5_no_tick_off: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> !strobe.tick || $past(tapPrev));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cntReg,
  output logic [DATA_W-1:0] modReg,
  output logic              irq
);
  logic atTop;
  assign atTop = (cntReg == {DATA_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             modReg <= '0;
    else if (strobe.modWr) modReg <= wdata;
  end

  // a bus write beats a tick on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (strobe.cntWr) begin
        cntReg <= wdata;
      end else if (strobe.tick) begin
        if (atTop) begin
          cntReg <= modReg;
          irq    <= 1'b1;
        end else begin
          cntReg <= cntReg + 1'b1;
        end
      end
    end
  end

  // R6: overflow reloads from the modulo register
  a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && atTop && !strobe.cntWr && !strobe.modWr) |=> (cntReg == $past(modReg)) && irq);

  // R7: request lasts a single cycle
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R9: bus write wins over a tick
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWr |=> cntReg == $past(wdata));

  // R5: counter holds without tick or write
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.cntWr) |=> $stable(cntReg));
endmodule

// File: rtl/modulo_interval_timer.sv
module modulo_interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned TAP_R0 = 7,
  parameter int unsigned TAP_R1 = 1,
  parameter int unsigned TAP_R2 = 3,
  parameter int unsigned TAP_R3 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              timerIrq
);
  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] divHigh;
  logic [CTL_W-1:0]  ctlReg;
  logic [DATA_W-1:0] cntReg;
  logic [DATA_W-1:0] modReg;

  tmr_ctrl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W),
    .TAP_R0(TAP_R0), .TAP_R1(TAP_R1), .TAP_R2(TAP_R2), .TAP_R3(TAP_R3)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .ctlWdata(busWdata[CTL_W-1:0]), .strobe(strobe),
    .divHigh(divHigh), .ctlReg(ctlReg)
  );

  tmr_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .cntReg(cntReg), .modReg(modReg), .irq(timerIrq)
  );

  always_comb begin
    unique case (busAddr)
      REG_DIV: busRdata = divHigh;
      REG_CNT: busRdata = cntReg;
      REG_MOD: busRdata = modReg;
      default: busRdata = DATA_W'(ctlReg);
    endcase
  end
endmodule

// File: tb/modulo_interval_timer_tb_top.sv
module modulo_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       timerIrq;

  int errors = 0;
  int checks = 0;
  int irqSeen = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  modulo_interval_timer dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .timerIrq(timerIrq)
  );

  always @(posedge clk) begin
    if (timerIrq) irqSeen <= irqSeen + 1;
    cycles <= cycles + 1;
  end

  typedef struct packed {
    logic [1:0]  rate;
    logic [7:0]  start;
    logic [7:0]  modv;
    logic [15:0] waitM;
    logic [7:0]  expCnt;
    logic [3:0]  expIrq;
  } vec_t;

  // rate, start, reload, edges since divider clear, expected count, expected irqs
  localparam vec_t VECS [7] = '{
    '{2'b01, 8'h00, 8'h00, 16'd21,  8'h05, 4'd0},  // R4 every 4
    '{2'b10, 8'h10, 8'h00, 16'd50,  8'h13, 4'd0},  // R4 every 16
    '{2'b11, 8'h00, 8'h00, 16'd200, 8'h03, 4'd0},  // R4 every 64
    '{2'b00, 8'h00, 8'h00, 16'd600, 8'h02, 4'd0},  // R4 every 256
    '{2'b01, 8'hFE, 8'h80, 16'd13,  8'h81, 4'd1},  // R6 reload
    '{2'b01, 8'hFD, 8'hFE, 16'd25,  8'hFF, 4'd2},  // R6 R7 repeated
    '{2'b10, 8'hFF, 8'h33, 16'd20,  8'h33, 4'd1}   // R6 slow rate
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // leaves the bench at the negedge after the control write (edge a+1)
  task automatic setup(input logic [1:0] rate, input logic [7:0] st, input logic [7:0] mv);
    busWrite(2'd3, 8'h00);
    busWrite(2'd2, mv);
    busWrite(2'd1, st);
    busWrite(2'd0, 8'h00);
    busWrite(2'd3, {5'b0, 1'b1, rate});
  endtask

  initial begin
    if (cycles > 150000) begin end
  end

  initial begin : watchdog
    wait (cycles >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", int'(timerIrq), 0);
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), rd);
      check("R1 reg", int'(rd), 0);
    end

    // R2 read/write and control field layout
    busWrite(2'd2, 8'hA5);
    busRead(2'd2, rd); check("R2 reload", int'(rd), 'hA5);
    busWrite(2'd1, 8'h3C);
    busRead(2'd1, rd); check("R2 counter", int'(rd), 'h3C);
    busWrite(2'd3, 8'hF9);
    busRead(2'd3, rd); check("R2 control", int'(rd), 'h01);

    // R3 divider readout and clear
    busWrite(2'd0, 8'hFF);
    repeat (299) @(negedge clk);
    busRead(2'd0, rd); check("R3 divider high byte", int'(rd), 'h01);
    busWrite(2'd0, 8'h12);
    busRead(2'd0, rd); check("R3 divider clear", int'(rd), 'h00);

    // table of rate and reload cases
    foreach (VECS[i]) begin
      setup(VECS[i].rate, VECS[i].start, VECS[i].modv);
      base = irqSeen;
      repeat (int'(VECS[i].waitM) - 1) @(negedge clk);
      busRead(2'd1, rd);
      check("R4 R6 count", int'(rd), int'(VECS[i].expCnt));
      check("R7 irq pulses", irqSeen - base, int'(VECS[i].expIrq));
    end

    // R8 and R5: disable while tick source high adds one tick, then frozen
    setup(2'b01, 8'h00, 8'h00);
    repeat (5) @(negedge clk);
    busWrite(2'd3, 8'h01);            // edge a+7
    repeat (2) @(negedge clk);
    busRead(2'd1, rd); check("R8 extra tick on disable", int'(rd), 2);
    repeat (60) @(negedge clk);
    busRead(2'd1, rd); check("R5 frozen", int'(rd), 2);

    // R8 divider clear while tick source high
    setup(2'b01, 8'h00, 8'h00);
    repeat (5) @(negedge clk);
    busWrite(2'd0, 8'h00);            // edge a+7
    repeat (3) @(negedge clk);        // negedge after a+10
    busRead(2'd1, rd); check("R8 extra tick on divider clear", int'(rd), 2);

    // R9 counter write on the tick edge
    setup(2'b01, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    busWrite(2'd1, 8'h40);            // edge a+5, a tick edge
    busRead(2'd1, rd); check("R9 write wins", int'(rd), 'h40);
    @(negedge clk);
    busRead(2'd1, rd); check("R9 no late tick", int'(rd), 'h40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule